// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired sequencer for a processor that runs each instruction over several clock cycles. A 4-bit state register names the current step. Every datapath strobe and mux select is a pure function of that state, with one exception: in the R-type write-back state, the ALU overflow flag also gates the register write. The next state is worked out from the current state, the 6-bit opcode held in the instruction register and, in the R-type write-back state only, the overflow flag.

Every instruction starts with a shared fetch step and a shared decode step. It then follows its own short path of states, and the last state on that path returns to fetch. Two trap states handle errors. The first catches an opcode the decoder does not know. The second catches an overflow during R-type write-back. Each trap state writes the exception PC and cause registers, sets a cause code, and steers the PC to a fixed handler address through the fourth leg of the PC source mux.

Encodings 12 to 15 of the state register are never entered. If the register ever holds one of them, the sequencer returns to fetch on the next edge.

Top module: `mcyc_ctrl`

## Requirements
- R1: `rst` is synchronous and active high. The edge that samples `rst`=1 loads state 0 (fetch), whatever the current state.
- R2: State 0 asserts `mem_rd`, `ir_wr` and `pc_wr`, with `alu_src_b`=1 and `pc_src`=0, and always moves to state 1. State 1 drives `alu_src_b`=3 and `alu_op`=0, with every strobe low.
- R3: Load (opcode 100011) visits states 0,1,2,3,4,0. State 2 drives `alu_src_a`=1 and `alu_src_b`=2. State 3 asserts `mem_rd` and `iord`. State 4 asserts `reg_wr` and `mem_to_reg`.
- R4: Store (opcode 101011) visits states 0,1,2,5,0. State 5 asserts `mem_wr` and `iord`.
- R5: R-type (opcode 000000) visits states 0,1,6,7,0. State 6 drives `alu_src_a`=1, `alu_src_b`=0 and `alu_op`=2. State 7 asserts `reg_dst` and `reg_wr`.
- R6: Branch-equal (opcode 000100) visits states 0,1,8,0. State 8 asserts `pc_wr_cond` and drives `pc_src`=1, `alu_op`=1 and `alu_src_a`=1.
- R7: Jump (opcode 000010) visits states 0,1,9,0. State 9 asserts `pc_wr` and drives `pc_src`=2.
- R8: `pc_wr` is high only in states 0, 9, 10 and 11.
- R9: Any other opcode in state 1 leads to state 10. State 10 asserts `epc_wr`, `cause_wr` and `pc_wr`, drives `pc_src`=3, `int_cause`=0, `alu_src_b`=1 and `alu_op`=1, and returns to state 0.
- R10: `ovf`=1 in state 7 leads to state 11 and holds `reg_wr` low in that cycle. State 11 has the same outputs as state 10 except `int_cause`=1, and it returns to state 0. Outside state 7, `ovf` has no effect on any output.
- R11: `state_nx` always shows the state that the next edge loads when `rst` is low.
- R12: `exc_vec` carries the handler address, 32'h8000_0180 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the held instruction |
| ovf | input | 1 | ALU overflow flag |
| state_q | output | 4 | Current state |
| state_nx | output | 4 | Next state |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if the ALU result is zero |
| iord | output | 1 | Memory address select: 0 = PC, 1 = ALU output register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register write |
| mem_to_reg | output | 1 | Register write data from the memory data register |
| reg_dst | output | 1 | Destination register from the rd field |
| reg_wr | output | 1 | Register file write |
| alu_src_a | output | 1 | ALU A select: 0 = PC, 1 = register A |
| alu_src_b | output | 2 | ALU B select: 0 = B, 1 = 4, 2 = immediate, 3 = shifted immediate |
| alu_op | output | 2 | 0 = add, 1 = subtract, 2 = function field |
| pc_src | output | 2 | PC source: 0 = ALU, 1 = ALU output register, 2 = jump target, 3 = handler |
| epc_wr | output | 1 | Exception PC write |
| cause_wr | output | 1 | Cause register write |
| int_cause | output | 1 | Cause code: 0 = undefined opcode, 1 = overflow |
| exc_vec | output | 32 | Handler address |

## Verification
All control outputs and `state_nx` are combinational from the state and the current inputs. The bench therefore checks them 1 time unit after it drives the inputs, in the same cycle. A change of state shows up on `state_q` one edge later. The reference model advances its state integer at the same edge, so each check compares against the state the model holds for that cycle. Overflow is driven high in states other than 7, and each such cycle is compared as well. A reset raised in the middle of a load is checked on the cycle right after the edge that samples it.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  localparam int ST_W = 4;
  localparam int OP_W = 6;

  localparam logic [ST_W-1:0] S_FETCH  = 4'd0;
  localparam logic [ST_W-1:0] S_DECODE = 4'd1;
  localparam logic [ST_W-1:0] S_MADDR  = 4'd2;
  localparam logic [ST_W-1:0] S_MREAD  = 4'd3;
  localparam logic [ST_W-1:0] S_LDWB   = 4'd4;
  localparam logic [ST_W-1:0] S_MWRITE = 4'd5;
  localparam logic [ST_W-1:0] S_EXEC   = 4'd6;
  localparam logic [ST_W-1:0] S_RWB    = 4'd7;
  localparam logic [ST_W-1:0] S_BRANCH = 4'd8;
  localparam logic [ST_W-1:0] S_JUMP   = 4'd9;
  localparam logic [ST_W-1:0] S_UNDEF  = 4'd10;
  localparam logic [ST_W-1:0] S_OVFL   = 4'd11;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_JUMP  = 6'b000010;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OP_STORE = 6'b101011;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       iord;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       mem_to_reg;
    logic       reg_dst;
    logic       reg_wr;
    logic       alu_src_a;
    logic [1:0] alu_src_b;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
    logic       epc_wr;
    logic       cause_wr;
    logic       int_cause;
  } ctrl_t;

  // Successor of a state; unused encodings fall back to fetch.
  function automatic logic [ST_W-1:0] next_of(input logic [ST_W-1:0] s,
                                              input logic [OP_W-1:0] op,
                                              input logic ov);
    logic [ST_W-1:0] n;
    n = S_FETCH;
    case (s)
      S_FETCH:  n = S_DECODE;
      S_DECODE: begin
        case (op)
          OP_RTYPE:          n = S_EXEC;
          OP_JUMP:           n = S_JUMP;
          OP_BEQ:            n = S_BRANCH;
          OP_LOAD, OP_STORE: n = S_MADDR;
          default:           n = S_UNDEF;
        endcase
      end
      S_MADDR:  n = (op == OP_LOAD) ? S_MREAD :
                    ((op == OP_STORE) ? S_MWRITE : S_FETCH);
      S_MREAD:  n = S_LDWB;
      S_EXEC:   n = S_RWB;
      S_RWB:    n = ov ? S_OVFL : S_FETCH;
      default:  n = S_FETCH;
    endcase
    return n;
  endfunction

  // Moore output word of a state.
  function automatic ctrl_t ctrl_of(input logic [ST_W-1:0] s);
    ctrl_t c;
    c = '0;
    case (s)
      S_FETCH: begin
        c.mem_rd = 1'b1; c.ir_wr = 1'b1; c.pc_wr = 1'b1; c.alu_src_b = 2'd1;
      end
      S_DECODE: c.alu_src_b = 2'd3;
      S_MADDR: begin
        c.alu_src_a = 1'b1; c.alu_src_b = 2'd2;
      end
      S_MREAD: begin
        c.mem_rd = 1'b1; c.iord = 1'b1;
      end
      S_LDWB: begin
        c.reg_wr = 1'b1; c.mem_to_reg = 1'b1;
      end
      S_MWRITE: begin
        c.mem_wr = 1'b1; c.iord = 1'b1;
      end
      S_EXEC: begin
        c.alu_src_a = 1'b1; c.alu_op = 2'd2;
      end
      S_RWB: begin
        c.reg_dst = 1'b1; c.reg_wr = 1'b1;
      end
      S_BRANCH: begin
        c.alu_src_a = 1'b1; c.alu_op = 2'd1; c.pc_wr_cond = 1'b1; c.pc_src = 2'd1;
      end
      S_JUMP: begin
        c.pc_wr = 1'b1; c.pc_src = 2'd2;
      end
      S_UNDEF, S_OVFL: begin
        c.epc_wr = 1'b1; c.cause_wr = 1'b1; c.pc_wr = 1'b1; c.pc_src = 2'd3;
        c.alu_src_b = 2'd1; c.alu_op = 2'd1;
        c.int_cause = (s == S_OVFL);
      end
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/mcyc_state_reg.sv
module mcyc_state_reg #(
  parameter int              W       = 4,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
  import mcyc_pkg::*;
(
  input  logic [ST_W-1:0] cur,
  input  logic [OP_W-1:0] op,
  input  logic            ov,
  output logic [ST_W-1:0] nxt
);
  always_comb nxt = next_of(cur, op, ov);
endmodule

// File: rtl/mcyc_out_dec.sv
module mcyc_out_dec
  import mcyc_pkg::*;
(
  input  logic [ST_W-1:0] cur,
  input  logic            ov,
  output ctrl_t           ctl
);
  always_comb begin
    ctl = ctrl_of(cur);
    // a faulting R-type result is not committed
    if (cur == S_RWB && ov) ctl.reg_wr = 1'b0;
  end
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
#(
  parameter int              VEC_W   = 32,
  parameter logic [VEC_W-1:0] EXC_VEC = 32'h8000_0180
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [5:0]       opcode,
  input  logic             ovf,
  output logic [3:0]       state_q,
  output logic [3:0]       state_nx,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic             iord,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_wr,
  output logic             mem_to_reg,
  output logic             reg_dst,
  output logic             reg_wr,
  output logic             alu_src_a,
  output logic [1:0]       alu_src_b,
  output logic [1:0]       alu_op,
  output logic [1:0]       pc_src,
  output logic             epc_wr,
  output logic             cause_wr,
  output logic             int_cause,
  output logic [VEC_W-1:0] exc_vec
);
  ctrl_t ctl;

  mcyc_state_reg #(.W(ST_W), .RST_VAL(S_FETCH)) u_sreg (
    .clk(clk), .rst(rst), .d(state_nx), .q(state_q)
  );

  mcyc_seq u_seq (.cur(state_q), .op(opcode), .ov(ovf), .nxt(state_nx));

  mcyc_out_dec u_dec (.cur(state_q), .ov(ovf), .ctl(ctl));

  // named events for the checker
  logic ovf_trap;
  logic undef_trap;
  assign ovf_trap   = (state_q == S_RWB) && ovf;
  assign undef_trap = (state_q == S_DECODE) && (state_nx == S_UNDEF);

  assign pc_wr      = ctl.pc_wr;
  assign pc_wr_cond = ctl.pc_wr_cond;
  assign iord       = ctl.iord;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign ir_wr      = ctl.ir_wr;
  assign mem_to_reg = ctl.mem_to_reg;
  assign reg_dst    = ctl.reg_dst;
  assign reg_wr     = ctl.reg_wr;
  assign alu_src_a  = ctl.alu_src_a;
  assign alu_src_b  = ctl.alu_src_b;
  assign alu_op     = ctl.alu_op;
  assign pc_src     = ctl.pc_src;
  assign epc_wr     = ctl.epc_wr;
  assign cause_wr   = ctl.cause_wr;
  assign int_cause  = ctl.int_cause;
  assign exc_vec    = EXC_VEC;
endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] state_q,
  input logic [3:0] state_nx,
  input logic       pc_wr,
  input logic       reg_wr,
  input logic       epc_wr,
  input logic       cause_wr,
  input logic       int_cause,
  input logic [1:0] pc_src,
  input logic       ovf_trap,
  input logic       undef_trap
);
  // R1
  reset_to_fetch_chk: assert property (@(posedge clk) rst |=> state_q == 4'd0);

  // R11
  next_state_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> state_q == $past(state_nx));

  // R2
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
    state_q == 4'd0 |=> state_q == 4'd1);

  // R8
  pc_write_states_chk: assert property (@(posedge clk) disable iff (rst)
    pc_wr |-> (state_q == 4'd0 || state_q == 4'd9 || state_q == 4'd10 || state_q == 4'd11));

  // R9
  undef_trap_chk: assert property (@(posedge clk) disable iff (rst)
    undef_trap |=> epc_wr && cause_wr && !int_cause && pc_src == 2'd3);

  // R10
  no_overflow_commit_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_trap |-> !reg_wr);

  // R10
  overflow_trap_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_trap |=> epc_wr && int_cause && state_nx == 4'd0);
endmodule

bind mcyc_ctrl mcyc_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .state_q(state_q), .state_nx(state_nx),
  .pc_wr(pc_wr), .reg_wr(reg_wr), .epc_wr(epc_wr), .cause_wr(cause_wr),
  .int_cause(int_cause), .pc_src(pc_src), .ovf_trap(ovf_trap),
  .undef_trap(undef_trap)
);

// File: tb/mcyc_ctrl_bench.sv
module mcyc_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = 6'd0;
  logic        ovf = 1'b0;
  logic [3:0]  state_q, state_nx;
  logic        pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr, mem_to_reg;
  logic        reg_dst, reg_wr, alu_src_a, epc_wr, cause_wr, int_cause;
  logic [1:0]  alu_src_b, alu_op, pc_src;
  logic [31:0] exc_vec;

  int n_cmp = 0;
  int n_bad = 0;
  int ref_state = -1;
  int noise = 5;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcyc_ctrl u_mcyc_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .ovf(ovf),
    .state_q(state_q), .state_nx(state_nx),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .iord(iord), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .ir_wr(ir_wr), .mem_to_reg(mem_to_reg), .reg_dst(reg_dst),
    .reg_wr(reg_wr), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
    .alu_op(alu_op), .pc_src(pc_src), .epc_wr(epc_wr), .cause_wr(cause_wr),
    .int_cause(int_cause), .exc_vec(exc_vec)
  );

  function automatic int mdl_next(int s, logic [5:0] op, bit ov);
    if (s == 0) return 1;
    if (s == 1) begin
      if (op == 6'h00) return 6;
      if (op == 6'h02) return 9;
      if (op == 6'h04) return 8;
      if (op == 6'h23 || op == 6'h2b) return 2;
      return 10;
    end
    if (s == 2) return (op == 6'h23) ? 3 : ((op == 6'h2b) ? 5 : 0);
    if (s == 3) return 4;
    if (s == 6) return 7;
    if (s == 7 && ov) return 11;
    return 0;
  endfunction

  // order: pc_wr pc_wr_cond iord mem_rd mem_wr ir_wr mem_to_reg reg_dst reg_wr
  //        alu_src_a alu_src_b alu_op pc_src epc_wr cause_wr int_cause
  function automatic logic [18:0] mdl_ctrl(int s, bit ov);
    bit trap;
    logic [1:0] sb, op2, ps;
    trap = (s == 10 || s == 11);
    sb  = (s == 0 || trap) ? 2'd1 : (s == 1) ? 2'd3 : (s == 2) ? 2'd2 : 2'd0;
    op2 = (s == 6) ? 2'd2 : (s == 8 || trap) ? 2'd1 : 2'd0;
    ps  = (s == 8) ? 2'd1 : (s == 9) ? 2'd2 : trap ? 2'd3 : 2'd0;
    return {(s == 0 || s == 9 || trap), (s == 8), (s == 3 || s == 5),
            (s == 0 || s == 3), (s == 5), (s == 0), (s == 4), (s == 7),
            (s == 4 || (s == 7 && !ov)), (s == 2 || s == 6 || s == 8),
            sb, op2, ps, trap, trap, (s == 11)};
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0, 1:    return "R2";
      2, 3, 4: return "R3";
      5:       return "R4";
      6, 7:    return "R5";
      8:       return "R6";
      9:       return "R7";
      10:      return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive, compare combinational outputs, cross the edge
  task automatic step(logic [5:0] op, bit ov, bit r);
    logic [18:0] act;
    int nx;
    opcode = op; ovf = ov; rst = r;
    #1;
    nx = (ref_state < 0) ? 0 : mdl_next(ref_state, op, ov);
    if (ref_state >= 0) begin
      act = {pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr, mem_to_reg, reg_dst,
             reg_wr, alu_src_a, alu_src_b, alu_op, pc_src, epc_wr, cause_wr, int_cause};
      check(tag_of(ref_state), "state", 32'(state_q), 32'(ref_state));
      check(tag_of(ref_state), "ctrl", 32'(act), 32'(mdl_ctrl(ref_state, ov)));
      check("R8", "pc_wr", 32'(pc_wr),
            32'(ref_state == 0 || ref_state == 9 || ref_state == 10 || ref_state == 11));
      check("R11", "state_nx", 32'(state_nx), 32'(nx));
    end
    @(posedge clk);
    ref_state = r ? 0 : nx;
    @(negedge clk);
  endtask

  // run one instruction from fetch back to fetch; ovf noise outside state 7 (R10)
  task automatic run_op(logic [5:0] op, bit ovf_at_wb);
    bit ov;
    do begin
      noise = (noise * 5 + 3) % 16;
      ov = (ref_state == 7) ? ovf_at_wb : noise[0];
      step(op, ov, 1'b0);
    end while (ref_state != 0);
  endtask

  initial begin
    @(negedge clk);
    step(6'h00, 1'b0, 1'b1);
    step(6'h00, 1'b0, 1'b1);
    #1 check("R1", "state after reset", 32'(state_q), 32'd0);
    check("R12", "exc_vec", exc_vec, 32'h8000_0180);
    run_op(6'h23, 1'b0);  // R3 load
    run_op(6'h2b, 1'b0);  // R4 store
    run_op(6'h00, 1'b0);  // R5 R-type
    run_op(6'h00, 1'b1);  // R10 overflow
    run_op(6'h04, 1'b0);  // R6 branch
    run_op(6'h02, 1'b0);  // R7 jump
    run_op(6'h3f, 1'b0);  // R9 undefined
    run_op(6'h08, 1'b0);  // R9 undefined
    run_op(6'h00, 1'b1);
    run_op(6'h23, 1'b0);
    // R1: reset in the middle of a load
    step(6'h23, 1'b0, 1'b0);
    step(6'h23, 1'b0, 1'b0);
    step(6'h23, 1'b0, 1'b0);
    step(6'h23, 1'b0, 1'b1);
    #1 check("R1", "state after mid-run reset", 32'(state_q), 32'd0);
    run_op(6'h2b, 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule